// File: doc/BRIEF.md
# PCM Receive Time-Slot Extractor

This block pulls a single channel's receive sample out of a serial PCM stream. It runs on the bit clock. A frame sync pulse marks bit position zero of each frame, and a position counter then advances by one per bit. The channel's sample begins at a programmable position. That position is made of a coarse time-slot number, where each slot is eight bits, and a fine offset of zero to seven bits that forms the low three bits of the position.

In companded mode the block shifts in one eight-bit slot. In linear mode it shifts in two adjacent slots for a sixteen-bit word. Bits arrive most significant first. After the last bit is captured, the block presents the word on a parallel output together with a one-cycle strobe.

A placement that runs past the end of the frame never produces a sample. Instead, the block raises an overrun pulse at each frame start. A new frame sync that arrives during a capture discards the partial word. A standby setting silences the channel completely. The block is meant to sit behind a channel's configuration store, one instance per channel, with the channel number fixed as a parameter.

Top module: `pcm_rx_slot_extract`

## Requirements
- R1: While reset is high and in the first cycle after it, rx_valid and rx_overrun are 0 and rx_data is all zeros.
- R2: A write with cfg_we high stores cfg_wdata into the register selected by cfg_addr:
  - address 0 is the time slot, taken from the low TS_W bits;
  - address 1 is the fine offset, taken from bits 2:0;
  - address 2 is control, where bit 0 is active and bit 1 is linear.
  After reset the time slot is 16*CHAN_ID (truncated to TS_W bits), the fine offset is 0, and the channel is in standby and companded mode.
- R3: The bit sampled in a cycle with fsync high is frame position 0, and each later cycle adds one. The sample's first bit is at position slot*8 + fine.
- R4: In companded mode, the 8 bits at positions start to start+7 appear MSB first (the earliest bit is MSB) in rx_data[7:0], with rx_data[15:8] zero.
- R5: In linear mode, the 16 bits at positions start to start+15 appear MSB first in rx_data[15:0].
- R6: rx_valid is high for exactly the one cycle after the clock edge that captured the last bit. rx_data holds its value between strobes.
- R7: When start + length exceeds the frame length (FRAME_SLOTS*8 bits), no strobe is produced. rx_overrun pulses for one cycle after each edge at which fsync is sampled high.
- R8: With active at 0, neither rx_valid nor rx_overrun is ever raised, whatever the data and the position.
- R9: A frame sync inside a sample window restarts the count at 0. The partial word is never strobed, and the sample is taken again from the new frame.
- R10: After reset, no capture occurs until the first fsync has been sampled, even if the position counter reaches the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; serial data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, high for the first bit of a frame |
| sdata | input | 1 | Serial receive data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rx_data | output | 16 | Captured sample word |
| rx_valid | output | 1 | One-cycle strobe when rx_data is updated |
| rx_overrun | output | 1 | One-cycle pulse at frame start when the window overruns the frame |

## Verification
The assertions assume three things about the inputs:
- fsync and sdata are steady at each rising edge;
- the configuration is rewritten only between frames, so the placement that the data path used for a capture matches the mode flags visible one cycle later;
- frames are long enough that a sample never completes in two consecutive cycles.

The stimulus drives all inputs on falling edges. It writes configuration only in idle gaps between frame runs, and in each run it sends a full frame of pseudo-random bits, or a frame cut short by a second sync.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int FINE_W    = 3;
  localparam int SLOT_BITS = 1 << FINE_W;
  localparam int WORD_W    = 2 * SLOT_BITS;
  localparam int CFG_DW    = 8;

  typedef enum logic [1:0] {
    REG_SLOT = 2'd0,
    REG_FINE = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic linear;
    logic active;
  } chan_ctrl_t;
endpackage

// File: rtl/pcm_rx_cfg.sv
module pcm_rx_cfg
  import pcm_rx_pkg::*;
#(
  parameter int TS_W    = 7,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [TS_W-1:0]   slot,
  output logic [FINE_W-1:0] fine,
  output chan_ctrl_t        ctrl
);
  localparam logic [TS_W-1:0] SLOT_DEF = TS_W'(16 * CHAN_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= SLOT_DEF;
      fine <= '0;
      ctrl <= '0;
    end else if (we) begin
      case (cfg_sel_e'(addr))
        REG_SLOT: slot <= wdata[TS_W-1:0];
        REG_FINE: fine <= wdata[FINE_W-1:0];
        REG_CTRL: begin
          ctrl.active <= wdata[0];
          ctrl.linear <= wdata[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer #(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  output logic [CNT_W-1:0] pos,
  output logic             in_frame,
  output logic             synced
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt_cnt;

  generate
    if ((FRAME_BITS & (FRAME_BITS - 1)) == 0) begin : g_pow2
      assign nxt_cnt = cnt_q + 1'b1;
    end else begin : g_mod
      assign nxt_cnt = (cnt_q == CNT_W'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  assign pos      = fsync ? '0 : nxt_cnt;
  assign in_frame = synced | fsync;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      synced <= 1'b0;
    end else begin
      cnt_q <= pos;
      if (fsync) synced <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_rx_window.sv
module pcm_rx_window
  import pcm_rx_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int CNT_W      = 8,
  parameter int TS_W       = 7,
  parameter int POS_W      = 11
) (
  input  logic [TS_W-1:0]   slot,
  input  logic [FINE_W-1:0] fine,
  input  logic              linear,
  input  logic [CNT_W-1:0]  pos,
  output logic              in_win,
  output logic              at_last,
  output logic              bad
);
  logic [POS_W-1:0] start;
  logic [POS_W-1:0] len;
  logic [POS_W-1:0] stop;
  logic [POS_W-1:0] last;
  logic [POS_W-1:0] p;

  always_comb begin
    start   = POS_W'({slot, fine});
    len     = linear ? POS_W'(WORD_W) : POS_W'(SLOT_BITS);
    stop    = start + len;
    last    = stop - 1'b1;
    p       = POS_W'(pos);
    bad     = stop > POS_W'(FRAME_BITS);
    in_win  = !bad && (p >= start) && (p <= last);
    at_last = !bad && (p == last);
  end
endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
  import pcm_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata,
  input  logic              enable,
  input  logic              in_win,
  input  logic              at_last,
  input  logic              linear,
  input  logic              ovf_req,
  output logic [WORD_W-1:0] data,
  output logic              valid,
  output logic              overrun
);
  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'({SLOT_BITS{1'b1}});

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_nxt;

  assign sh_nxt = {sh_q[WORD_W-2:0], sdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      data    <= '0;
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      valid   <= 1'b0;
      overrun <= 1'b0;
      if (enable) begin
        if (in_win) sh_q <= sh_nxt;
        if (at_last) begin
          valid <= 1'b1;
          data  <= linear ? sh_nxt : (sh_nxt & LOW_MASK);
        end
        overrun <= ovf_req;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_slot_extract.sv
module pcm_rx_slot_extract
  import pcm_rx_pkg::*;
#(
  parameter int FRAME_SLOTS = 32,
  parameter int TS_W        = 7,
  parameter int CHAN_ID     = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              sdata,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_overrun
);
  localparam int FRAME_BITS = FRAME_SLOTS * SLOT_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int SPAN_W     = (TS_W + FINE_W > CNT_W) ? TS_W + FINE_W : CNT_W;
  localparam int POS_W      = SPAN_W + 2;

  logic [TS_W-1:0]   slot_q;
  logic [FINE_W-1:0] fine_q;
  chan_ctrl_t        ctrl_q;
  logic              chan_active;
  logic              chan_linear;
  logic [CNT_W-1:0]  pos;
  logic              in_frame;
  logic              synced;
  logic              in_win;
  logic              at_last;
  logic              bad;

  assign chan_active = ctrl_q.active;
  assign chan_linear = ctrl_q.linear;

  pcm_rx_cfg #(.TS_W(TS_W), .CHAN_ID(CHAN_ID)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .slot(slot_q), .fine(fine_q), .ctrl(ctrl_q)
  );

  pcm_rx_framer #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .fsync(fsync),
    .pos(pos), .in_frame(in_frame), .synced(synced)
  );

  pcm_rx_window #(
    .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W), .TS_W(TS_W), .POS_W(POS_W)
  ) u_window (
    .slot(slot_q), .fine(fine_q), .linear(chan_linear), .pos(pos),
    .in_win(in_win), .at_last(at_last), .bad(bad)
  );

  pcm_rx_capture u_capture (
    .clk(clk), .rst(rst), .sdata(sdata),
    .enable(chan_active & in_frame),
    .in_win(in_win), .at_last(at_last), .linear(chan_linear),
    .ovf_req(fsync & bad),
    .data(rx_data), .valid(rx_valid), .overrun(rx_overrun)
  );
endmodule

// File: rtl/pcm_rx_slot_extract_chk.sv
module pcm_rx_slot_extract_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fsync,
  input logic              active,
  input logic              linear,
  input logic              synced,
  input logic              rx_valid,
  input logic              rx_overrun,
  input logic [WORD_W-1:0] rx_data
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data)); // R6

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!rx_valid && !rx_overrun)); // R8

  AST_OVF_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> $past(fsync)); // R7

  AST_NO_VALID_WITH_OVF: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_overrun)); // R7

  AST_COMPANDED_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !$past(linear)) |-> (rx_data[WORD_W-1:WORD_W/2] == '0)); // R4

  AST_NO_CAPTURE_UNSYNCED: assert property (@(posedge clk) disable iff (rst)
    (!synced && !fsync) |=> !rx_valid); // R10
endmodule

bind pcm_rx_slot_extract pcm_rx_slot_extract_chk #(.WORD_W(16)) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync), .active(chan_active), .linear(chan_linear),
  .synced(synced), .rx_valid(rx_valid), .rx_overrun(rx_overrun), .rx_data(rx_data)
);

// File: tb/pcm_rx_slot_extract_tb.sv
`timescale 1ns/1ps
module pcm_rx_slot_extract_tb;
  localparam int FS   = 32;
  localparam int TSW  = 6;
  localparam int CH   = 1;
  localparam int FB   = FS * 8;
  localparam int MAXN = 2 * FB + 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync = 1'b0;
  logic        sdata = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [15:0] rx_data;
  logic        rx_valid;
  logic        rx_overrun;

  always #10 clk = ~clk;

  pcm_rx_slot_extract #(.FRAME_SLOTS(FS), .TS_W(TSW), .CHAN_ID(CH)) u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .sdata(sdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_overrun(rx_overrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m_slot, m_fine;
  bit m_lin, m_act;
  logic st_bit [MAXN];
  int   st_pos [MAXN];
  bit   st_fs  [MAXN];
  logic [15:0] held;
  logic [15:0] lfsr = 16'hACE1;

  task automatic expect_eq(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input int s, input int f, input bit l, input bit a);
    wr(2'd0, 8'(s));
    wr(2'd1, 8'(f));
    wr(2'd2, {6'd0, l, a});
    m_slot = s; m_fine = f; m_lin = l; m_act = a;
  endtask

  task automatic check_at(input int j, input string tag);
    int start, len;
    bit bad, ev, eo;
    logic [15:0] ed;
    start = m_slot * 8 + m_fine;
    len   = m_lin ? 16 : 8;
    bad   = (start + len) > FB;
    ev    = m_act && !bad && (st_pos[j] == start + len - 1);
    eo    = m_act && bad && st_fs[j];
    expect_eq(tag, "valid", int'(rx_valid), int'(ev));
    expect_eq(tag, "overrun", int'(rx_overrun), int'(eo));
    if (ev) begin
      ed = '0;
      for (int b = 0; b < len; b++) ed = {ed[14:0], st_bit[j - len + 1 + b]};
      expect_eq(tag, "data", int'(rx_data), int'(ed));
      held = ed;
    end else begin
      expect_eq("R6", "held data", int'(rx_data), int'(held));
    end
  endtask

  task automatic run_seq(input int n, input int restart, input string tag);
    int p;
    p = 0;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k == 0) held = rx_data;
      else check_at(k - 1, tag);
      if (k < n) begin
        bit f;
        f = (k == 0) || (k == restart);
        p = f ? 0 : p + 1;
        st_fs[k] = f; st_pos[k] = p; st_bit[k] = lfsr[0];
        fsync = f; sdata = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end else begin
        fsync = 1'b0; sdata = 1'b0;
      end
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    expect_eq("R1", "valid in reset", int'(rx_valid), 0);
    expect_eq("R1", "data in reset", int'(rx_data), 0);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1", "valid", int'(rx_valid), 0);
    expect_eq("R1", "overrun", int'(rx_overrun), 0);
    expect_eq("R1", "data", int'(rx_data), 0);

    // R10: active with default placement, counter passes the window without any sync
    wr(2'd2, 8'h01);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      expect_eq("R10", "valid before sync", int'(rx_valid), 0);
      expect_eq("R10", "overrun before sync", int'(rx_overrun), 0);
      sdata = lfsr[0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // R2: default slot 16*CHAN_ID, fine 0, companded
    m_slot = 16 * CH; m_fine = 0; m_lin = 1'b0; m_act = 1'b1;
    run_seq(FB, -1, "R2");

    // R3/R4/R5/R7 sweep over placement and mode
    for (int lin = 0; lin < 2; lin++) begin
      for (int s = 0; s < 34; s++) begin
        for (int f = 0; f < 8; f++) begin
          int st;
          if (!(f == 0 || f == 1 || f == 7 || s == 2)) continue;
          set_cfg(s, f, lin[0], 1'b1);
          st = s * 8 + f;
          if (st + (lin != 0 ? 16 : 8) > FB) run_seq(FB, -1, "R3/R7");
          else if (lin != 0) run_seq(FB, -1, "R3/R5");
          else run_seq(FB, -1, "R3/R4");
        end
      end
    end

    // R8: standby, both with a fitting window and an overrunning one
    set_cfg(3, 2, 1'b0, 1'b0);
    run_seq(FB, -1, "R8");
    set_cfg(33, 0, 1'b1, 1'b0);
    run_seq(FB, -1, "R8");

    // R9: second sync in the middle of a linear window (positions 21..36)
    set_cfg(2, 5, 1'b1, 1'b1);
    run_seq(30 + FB, 30, "R9");

    finish_run();
  end
endmodule